// File: doc/BRIEF.md
# Interrupt Number Priority Resolver

This block looks at three 32-bit pending words each clock and names the one interrupt that software should service next. The three words are a summary word and two bank words. The summary word holds the pending lines of the local bank, a set of shortcut lines for selected bank interrupts, and one "anything pending" flag for each bank word. The block picks a group by fixed priority and picks the highest-numbered set bit inside that group. It then turns that bit into a 7-bit global interrupt number. Shortcut hits are converted through a built-in table of eleven global numbers.

The result is registered. One clock after the pending words are presented, the number, a valid flag and a spurious flag appear at the outputs. Valid reports that any input word was nonzero. Spurious reports that no group could produce a number, and the number is then forced to 0.

The outputs carry no ready signal and cannot be stalled. A new result is produced on every clock. A consumer that wants to hold a result has to capture it itself in the cycle it appears.

Top module: `irq_num_resolver`

## Requirements
- R1: While reset is active, and in the first cycle after it, the outputs are number 0, valid 0 and spurious 0. Every result appears exactly one clock after the inputs it is computed from.
- R2: valid is 1 exactly when, one clock earlier, at least one of the three input words was nonzero.
- R3: If any of summary bits 0..7 is set, that group wins over all others. The highest set bit b among them gives number 64 + b, with spurious 0.
- R4: If summary bits 0..7 are clear and any of summary bits 10..20 is set, take the highest set position k = bit - 10. The number is entry k of the table {7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62}, listed from k = 0 upward, with spurious 0.
- R5: If summary bits 0..7 and 10..20 are clear and summary bit 8 is set, the number is the index of the highest set bit of the bank 0 word (0..31).
- R6: If summary bits 0..8 and 10..20 are clear and summary bit 9 is set, the number is 32 plus the index of the highest set bit of the bank 1 word.
- R7: If none of summary bits 0..20 is set, spurious is 1 and the number is 0. Summary bits 21..31 never select a group.
- R8: If the selected bank flag (bit 8 or bit 9) is set but its bank word is all zero, the result is spurious with number 0. A set bit 9 does not take over when bit 8 is selected with an empty bank 0 word.
- R9: A bank word has no effect on the number while its summary flag is clear or a higher-priority group has a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sum_pend_i | input | 32 | Summary pending word: local bits, bank flags, shortcut bits |
| bank0_pend_i | input | 32 | Bank 0 pending word |
| bank1_pend_i | input | 32 | Bank 1 pending word |
| irq_num_o | output | 7 | Global number of the interrupt to service |
| valid_o | output | 1 | Some input word was nonzero one clock earlier |
| spurious_o | output | 1 | No group produced a number; irq_num_o is 0 |

## Verification
Each of the three outputs is due exactly one rising edge after its inputs are applied. The same holds for all of them, because they share one register stage. The driver applies each input set on a falling edge and pushes the expected number and flags into a queue shortly afterwards. The monitor pops and compares on the next falling edge, which is half a cycle after the edge that loaded the result. This way a check never samples the outputs at the edge where they change. The stimulus covers each group alone, the contests between groups, empty bank words under a set flag, and the ignored summary bits.

// File: rtl/irq_num_resolver_pkg.sv
package irq_num_resolver_pkg;
  localparam int WORD_W     = 32;
  localparam int NUM_W      = 7;
  localparam int LOCAL_W    = 8;
  localparam int LOCAL_BANK = 2;
  localparam int FLAG0_BIT  = 8;
  localparam int FLAG1_BIT  = 9;
  localparam int SC_LO      = 10;
  localparam int SC_N       = 11;
  localparam int SC_IW      = $clog2(SC_N);

  typedef struct packed {
    logic [NUM_W-1:0] num;
    logic             valid;
    logic             spurious;
  } irq_result_t;

  function automatic logic [NUM_W-1:0] shortcut_num(input logic [SC_IW-1:0] k);
    case (k)
      4'd0:    return 7'd7;
      4'd1:    return 7'd9;
      4'd2:    return 7'd10;
      4'd3:    return 7'd18;
      4'd4:    return 7'd19;
      4'd5:    return 7'd53;
      4'd6:    return 7'd54;
      4'd7:    return 7'd55;
      4'd8:    return 7'd56;
      4'd9:    return 7'd57;
      4'd10:   return 7'd62;
      default: return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/msb_pick.sv
module msb_pick #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/group_select.sv
module group_select
  import irq_num_resolver_pkg::*;
#(
  localparam int LIW = $clog2(LOCAL_W),
  localparam int BIW = $clog2(WORD_W)
) (
  input  logic             local_any_i,
  input  logic [LIW-1:0]   local_idx_i,
  input  logic             sc_any_i,
  input  logic [SC_IW-1:0] sc_idx_i,
  input  logic             flag0_i,
  input  logic             flag1_i,
  input  logic             bank0_any_i,
  input  logic [BIW-1:0]   bank0_idx_i,
  input  logic             bank1_any_i,
  input  logic [BIW-1:0]   bank1_idx_i,
  output logic [NUM_W-1:0] num_o,
  output logic             hit_o
);
  localparam logic [NUM_W-1:0] LocalBase = NUM_W'(LOCAL_BANK * WORD_W);
  localparam logic [NUM_W-1:0] Bank1Base = NUM_W'(WORD_W);

  always_comb begin
    num_o = '0;
    hit_o = 1'b0;
    if (local_any_i) begin
      num_o = LocalBase + NUM_W'(local_idx_i);
      hit_o = 1'b1;
    end else if (sc_any_i) begin
      num_o = shortcut_num(sc_idx_i);
      hit_o = 1'b1;
    end else if (flag0_i) begin
      if (bank0_any_i) begin
        num_o = NUM_W'(bank0_idx_i);
        hit_o = 1'b1;
      end
    end else if (flag1_i) begin
      if (bank1_any_i) begin
        num_o = Bank1Base + NUM_W'(bank1_idx_i);
        hit_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_num_resolver.sv
module irq_num_resolver
  import irq_num_resolver_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sum_pend_i,
  input  logic [WORD_W-1:0] bank0_pend_i,
  input  logic [WORD_W-1:0] bank1_pend_i,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic              valid_o,
  output logic              spurious_o
);
  localparam int LIW = $clog2(LOCAL_W);
  localparam int BIW = $clog2(WORD_W);

  logic             local_any, sc_any, bank0_any, bank1_any, hit;
  logic [LIW-1:0]   local_idx;
  logic [SC_IW-1:0] sc_idx;
  logic [BIW-1:0]   bank0_idx, bank1_idx;
  logic [NUM_W-1:0] num_d;
  irq_result_t      res_d, res_q;

  msb_pick #(.W(LOCAL_W)) u_local (
    .vec_i(sum_pend_i[LOCAL_W-1:0]), .any_o(local_any), .idx_o(local_idx));

  msb_pick #(.W(SC_N)) u_short (
    .vec_i(sum_pend_i[SC_LO+SC_N-1:SC_LO]), .any_o(sc_any), .idx_o(sc_idx));

  msb_pick #(.W(WORD_W)) u_bank0 (
    .vec_i(bank0_pend_i), .any_o(bank0_any), .idx_o(bank0_idx));

  msb_pick #(.W(WORD_W)) u_bank1 (
    .vec_i(bank1_pend_i), .any_o(bank1_any), .idx_o(bank1_idx));

  group_select u_sel (
    .local_any_i(local_any), .local_idx_i(local_idx),
    .sc_any_i(sc_any),       .sc_idx_i(sc_idx),
    .flag0_i(sum_pend_i[FLAG0_BIT]), .flag1_i(sum_pend_i[FLAG1_BIT]),
    .bank0_any_i(bank0_any), .bank0_idx_i(bank0_idx),
    .bank1_any_i(bank1_any), .bank1_idx_i(bank1_idx),
    .num_o(num_d), .hit_o(hit));

  always_comb begin
    res_d.num      = num_d;
    res_d.valid    = |{sum_pend_i, bank0_pend_i, bank1_pend_i};
    res_d.spurious = ~hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign irq_num_o  = res_q.num;
  assign valid_o    = res_q.valid;
  assign spurious_o = res_q.spurious;
endmodule

// File: rtl/irq_num_resolver_chk.sv
module irq_num_resolver_chk
  import irq_num_resolver_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] sum_pend_i,
  input logic [WORD_W-1:0] bank0_pend_i,
  input logic [WORD_W-1:0] bank1_pend_i,
  input logic [NUM_W-1:0]  irq_num_o,
  input logic              valid_o,
  input logic              spurious_o
);
  logic any_in;
  assign any_in = |{sum_pend_i, bank0_pend_i, bank1_pend_i};

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (valid_o == $past(any_in)));

  // R7
  spurious_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> (irq_num_o == '0));

  // R3
  local_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_pend_i[LOCAL_W-1:0] != '0) |=>
      (!spurious_o && irq_num_o >= 7'd64 && irq_num_o <= 7'd71));

  // R4
  shortcut_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_pend_i[LOCAL_W-1:0] == '0 && sum_pend_i[SC_LO+SC_N-1:SC_LO] != '0)
      |=> (!spurious_o && irq_num_o < 7'd64));

  // R7
  nothing_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_pend_i[SC_LO+SC_N-1:0] == '0) |=> spurious_o);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && !spurious_o && irq_num_o == '0));
endmodule

bind irq_num_resolver irq_num_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sum_pend_i(sum_pend_i),
  .bank0_pend_i(bank0_pend_i), .bank1_pend_i(bank1_pend_i),
  .irq_num_o(irq_num_o), .valid_o(valid_o), .spurious_o(spurious_o));

// File: tb/test_irq_num_resolver.sv
`timescale 1ns/1ps
module test_irq_num_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] sum_w = '0, b0_w = '0, b1_w = '0;
  logic [6:0]  num;
  logic        valid, spur;

  typedef struct {
    logic [6:0] num;
    logic       valid;
    logic       spur;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int sc_tab[11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

  always #2 clk = ~clk;

  irq_num_resolver i_irq_num_resolver (
    .clk(clk), .rst_n(rst_n), .sum_pend_i(sum_w),
    .bank0_pend_i(b0_w), .bank1_pend_i(b1_w),
    .irq_num_o(num), .valid_o(valid), .spurious_o(spur));

  function automatic int top_bit(input logic [31:0] v, input int lo, input int hi);
    for (int i = hi; i >= lo; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic exp_t model(input logic [31:0] s, input logic [31:0] a,
                                 input logic [31:0] b, input string tag);
    exp_t e;
    int p;
    e.tag = tag;
    e.valid = (s != 0) || (a != 0) || (b != 0);
    e.spur = 1'b1;
    e.num = 7'd0;
    p = top_bit(s, 0, 7);
    if (p >= 0) begin e.num = 7'(64 + p); e.spur = 0; return e; end
    p = top_bit(s, 10, 20);
    if (p >= 0) begin e.num = 7'(sc_tab[p-10]); e.spur = 0; return e; end
    if (s[8]) begin
      p = top_bit(a, 0, 31);
      if (p >= 0) begin e.num = 7'(p); e.spur = 0; end
      return e;
    end
    if (s[9]) begin
      p = top_bit(b, 0, 31);
      if (p >= 0) begin e.num = 7'(32 + p); e.spur = 0; end
    end
    return e;
  endfunction

  task automatic drive(input logic [31:0] s, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    sum_w = s; b0_w = a; b1_w = b;
    #1 exp_q.push_back(model(s, a, b, tag));
  endtask

  // monitor: result is due one rising edge after the drive, sampled at next fall
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (num !== e.num || valid !== e.valid || spur !== e.spur) begin
        fails++;
        $display("FAIL %s: got num=%0d valid=%0b spur=%0b, expected num=%0d valid=%0b spur=%0b",
                 e.tag, num, valid, spur, e.num, e.valid, e.spur);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (num !== 0 || valid !== 0 || spur !== 0) begin
      fails++;
      $display("FAIL R1: got num=%0d valid=%0b spur=%0b, expected 0 0 0", num, valid, spur);
    end
    rst_n = 1'b1;
    drive(32'h0, 32'h0, 32'h0, "R1_R7 idle");
    drive(32'h0000_0001, 0, 0, "R3 local bit0");
    drive(32'h0000_0090, 0, 0, "R3 local highest wins");
    drive(32'h001F_FF80, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 local beats all");
    drive(32'h0000_0400, 0, 0, "R4 shortcut k0");
    drive(32'h0010_0000, 0, 0, "R4 shortcut k10");
    drive(32'h0002_4300, 32'h1, 32'h1, "R4 shortcut highest over flags");
    for (int k = 0; k < 11; k++) drive(32'h1 << (10 + k), 0, 0, "R4 table walk");
    drive(32'h0000_0100, 32'h8000_0001, 0, "R5 bank0 top bit 31");
    drive(32'h0000_0300, 32'h0000_0010, 32'hFFFF_FFFF, "R5 bank0 over bank1");
    drive(32'h0000_0200, 32'h0, 32'h0000_0001, "R6 bank1 bit0");
    drive(32'h0000_0200, 32'hFFFF_FFFF, 32'h4000_0000, "R6 bank1 bit30");
    drive(32'hFFE0_0000, 32'h0, 32'h0, "R7 upper summary bits ignored");
    drive(32'h0000_0100, 32'h0, 32'h8000_0000, "R8 empty bank0 is spurious");
    drive(32'h0000_0200, 32'h0, 32'h0, "R8 empty bank1 is spurious");
    drive(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 banks ignored without flags");
    drive(32'h0000_0004, 32'h8000_0000, 32'h8000_0000, "R9 banks ignored under local");
    drive(32'h0, 32'h0, 32'h0, "R2 valid falls");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule